// File: doc/BRIEF.md
# Wishbone Address-Decode Interconnect

This block joins a single Wishbone master, normally a processor port, to a parameterised set of Wishbone slave ports. Every slave port has a base address. A fixed number of the most significant master address bits, the decode width, is compared against the same bits of each base address. One comparator is built for each port. The slave whose comparator matches gets the master's strobe and cycle. The acknowledge and read data of that slave are steered back to the master. Write data, byte selects and write enable go to every slave unchanged.

The master address width follows a mode parameter. Peripheral I/O mode uses 24 bits. Memory mode uses 32 bits. Each slave lane receives only its own number of low master address bits, and the remaining bits of that lane are zero. The Wishbone handshake is the only flow control. A slave applies back-pressure by holding its acknowledge low, and the master keeps strobe and cycle asserted until an acknowledge comes back. The interconnect adds no buffering and no wait state. Two ports with the same decoded base bits are rejected when the design is elaborated.

Top module: `wb_addr_decoder`

## Requirements
- R1: A slave port is selected when the top DEC_W bits of the master address equal the top DEC_W bits of that port's base address. The address bits below the decoded field have no effect on which port is selected.
- R2: A port's strobe and cycle outputs are both high exactly when master strobe, master cycle and that port's match are all high. If master strobe or master cycle is low, every slave strobe and cycle output is low.
- R3: At most one slave strobe is high at any time. Two ports whose decoded base bits are identical cause an elaboration error.
- R4: The master acknowledge equals the acknowledge of the strobed slave. Acknowledges from slaves that are not strobed are ignored. Master read data is the read data of the port whose comparator matches.
- R5: When no port matches, the master acknowledge is low and the master read data is all zeros.
- R6: Master write data, byte selects and write enable appear on the shared slave outputs unchanged, whatever the selection.
- R7: Slave lane i carries the low SIZE[i] bits of the master address, and the lane's bits above SIZE[i] are zero. With the default sizes, SIZE[i] is the address width minus DEC_W.
- R8: In I/O mode (MODE=WBD_IO, address width 24) with default parameters, bits [23:16] are decoded. The default base of port i is 0xFF000000 + i*0x10000, so port i is selected when address bits [23:16] equal i.
- R9: In memory mode (MODE=WBD_MEM, address width 32) with default parameters, bits [31:24] are decoded. The default base of port i is 0x01000000 + i*0x01000000, so port i is selected when address bits [31:24] equal i+1.
- R10: With DEC_W=2 and I/O bases 0xFF000000, 0xFF400000 and 0xFF800000, address bits [23:22] equal to 00, 01 and 10 select ports 0, 1 and 2. The value 11 selects no port.
- R11: The decode, the gating and the return path contain no registers. Every output follows its inputs within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_adr_i | input | ADDR_W | Master address |
| m_dat_i | input | DATA_W | Master write data |
| m_sel_i | input | DATA_W/8 | Master byte selects |
| m_we_i | input | 1 | Master write enable |
| m_stb_i | input | 1 | Master strobe |
| m_cyc_i | input | 1 | Master cycle |
| m_dat_o | output | DATA_W | Read data returned to master |
| m_ack_o | output | 1 | Acknowledge returned to master |
| s_adr_o | output | N_SLV*ADDR_W | Per-slave address lanes, lane i at bits [i*ADDR_W +: ADDR_W] |
| s_dat_o | output | DATA_W | Write data shared by all slaves |
| s_sel_o | output | DATA_W/8 | Byte selects shared by all slaves |
| s_we_o | output | 1 | Write enable shared by all slaves |
| s_stb_o | output | N_SLV | Per-slave gated strobe |
| s_cyc_o | output | N_SLV | Per-slave gated cycle |
| s_dat_i | input | N_SLV*DATA_W | Per-slave read data, slave i at bits [i*DATA_W +: DATA_W] |
| s_ack_i | input | N_SLV | Per-slave acknowledge |

## Verification
Every result of this block is due in the same clock cycle as the stimulus that causes it, because the decode and the response steering contain no register. The bench applies each master request and each set of slave acknowledges one nanosecond after a rising edge. It samples all outputs at the following falling edge, so each comparison sees settled logic belonging to that one request. Three instances run side by side: default I/O mode, default memory mode, and a narrow two-bit decode. Each request is scored against every instance.

// File: rtl/wbdec_pkg.sv
package wbdec_pkg;

  typedef enum logic {
    WBD_IO  = 1'b0,
    WBD_MEM = 1'b1
  } wbdec_mode_e;

  localparam int MAX_SLV = 16;

  function automatic int addr_width(input wbdec_mode_e mode);
    return (mode == WBD_MEM) ? 32 : 24;
  endfunction

  function automatic logic [MAX_SLV-1:0][31:0] default_bases(input wbdec_mode_e mode);
    logic [MAX_SLV-1:0][31:0] b;
    for (int i = 0; i < MAX_SLV; i++) begin
      if (mode == WBD_MEM) b[i] = 32'h0100_0000 + 32'(i) * 32'h0100_0000;
      else                 b[i] = 32'hFF00_0000 + 32'(i) * 32'h0001_0000;
    end
    return b;
  endfunction

  function automatic logic [MAX_SLV-1:0][5:0] uniform_sizes(input int width);
    logic [MAX_SLV-1:0][5:0] s;
    for (int i = 0; i < MAX_SLV; i++) s[i] = 6'(width);
    return s;
  endfunction

endpackage

// File: rtl/wbdec_match.sv
module wbdec_match #(
  parameter int DEC_W = 8,
  parameter logic [DEC_W-1:0] REF = '0
) (
  input  logic [DEC_W-1:0] top_bits_i,
  output logic             hit_o
);
  // One equality comparator per slave port on the decoded address field.
  assign hit_o = (top_bits_i == REF);
endmodule

// File: rtl/wbdec_lane.sv
module wbdec_lane #(
  parameter int ADDR_W = 24,
  parameter int SIZE   = 16
) (
  input  logic [ADDR_W-1:0] adr_i,
  output logic [ADDR_W-1:0] adr_o
);
  // Keep the low SIZE bits, clear everything above them.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b < SIZE) begin : g_keep
      assign adr_o[b] = adr_i[b];
    end else begin : g_zero
      assign adr_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/wbdec_ret.sv
module wbdec_ret #(
  parameter int N_SLV  = 4,
  parameter int DATA_W = 32
) (
  input  logic [N_SLV-1:0]        hit_i,
  input  logic [N_SLV-1:0]        strobe_i,
  input  logic [N_SLV*DATA_W-1:0] s_dat_i,
  input  logic [N_SLV-1:0]        s_ack_i,
  output logic [DATA_W-1:0]       m_dat_o,
  output logic                    m_ack_o
);
  // AND-OR steering; the hit vector is at most one-hot by construction of
  // the base map, so the OR merges a single contributor.
  always_comb begin
    m_dat_o = '0;
    m_ack_o = 1'b0;
    for (int i = 0; i < N_SLV; i++) begin
      if (hit_i[i]) m_dat_o = m_dat_o | s_dat_i[i*DATA_W +: DATA_W];
      m_ack_o = m_ack_o | (strobe_i[i] & s_ack_i[i]);
    end
  end
endmodule

// File: rtl/wb_addr_decoder.sv
module wb_addr_decoder
  import wbdec_pkg::*;
#(
  parameter wbdec_mode_e MODE = WBD_IO,
  parameter int N_SLV  = 4,
  parameter int DEC_W  = 8,
  parameter int DATA_W = 32,
  parameter logic [MAX_SLV-1:0][31:0] BASE = default_bases(MODE),
  parameter logic [MAX_SLV-1:0][5:0]  SIZE = uniform_sizes(addr_width(MODE) - DEC_W),
  localparam int ADDR_W = addr_width(MODE),
  localparam int SEL_W  = DATA_W / 8
) (
  input  logic [ADDR_W-1:0]       m_adr_i,
  input  logic [DATA_W-1:0]       m_dat_i,
  input  logic [SEL_W-1:0]        m_sel_i,
  input  logic                    m_we_i,
  input  logic                    m_stb_i,
  input  logic                    m_cyc_i,
  output logic [DATA_W-1:0]       m_dat_o,
  output logic                    m_ack_o,
  output logic [N_SLV*ADDR_W-1:0] s_adr_o,
  output logic [DATA_W-1:0]       s_dat_o,
  output logic [SEL_W-1:0]        s_sel_o,
  output logic                    s_we_o,
  output logic [N_SLV-1:0]        s_stb_o,
  output logic [N_SLV-1:0]        s_cyc_o,
  input  logic [N_SLV*DATA_W-1:0] s_dat_i,
  input  logic [N_SLV-1:0]        s_ack_i
);

  // Elaboration-time parameter checks.
  if (N_SLV < 1 || N_SLV > MAX_SLV) begin : g_bad_count
    $error("wb_addr_decoder: N_SLV out of range");
  end
  if (DEC_W < 1 || DEC_W > ADDR_W) begin : g_bad_dec
    $error("wb_addr_decoder: DEC_W out of range");
  end
  if (N_SLV > (1 << DEC_W)) begin : g_bad_fit
    $error("wb_addr_decoder: more ports than decodable values");
  end
  for (genvar i = 0; i < N_SLV; i++) begin : g_ovl_i
    for (genvar j = i + 1; j < N_SLV; j++) begin : g_ovl_j
      if (BASE[i][ADDR_W-1 -: DEC_W] == BASE[j][ADDR_W-1 -: DEC_W]) begin : g_clash
        $error("wb_addr_decoder: overlapping decode between two ports");
      end
    end
  end

  logic                 master_req;
  logic [N_SLV-1:0]     hit;
  logic [N_SLV-1:0]     strobe;
  logic [DEC_W-1:0]     top_field;

  assign master_req = m_stb_i & m_cyc_i;
  assign top_field  = m_adr_i[ADDR_W-1 -: DEC_W];

  for (genvar i = 0; i < N_SLV; i++) begin : g_port
    wbdec_match #(
      .DEC_W (DEC_W),
      .REF   (BASE[i][ADDR_W-1 -: DEC_W])
    ) u_match (
      .top_bits_i (top_field),
      .hit_o      (hit[i])
    );

    assign strobe[i] = master_req & hit[i];

    wbdec_lane #(
      .ADDR_W (ADDR_W),
      .SIZE   (int'(SIZE[i]))
    ) u_lane (
      .adr_i (m_adr_i),
      .adr_o (s_adr_o[i*ADDR_W +: ADDR_W])
    );
  end

  assign s_stb_o = strobe;
  assign s_cyc_o = strobe;
  assign s_dat_o = m_dat_i;
  assign s_sel_o = m_sel_i;
  assign s_we_o  = m_we_i;

  wbdec_ret #(
    .N_SLV  (N_SLV),
    .DATA_W (DATA_W)
  ) u_ret (
    .hit_i    (hit),
    .strobe_i (strobe),
    .s_dat_i  (s_dat_i),
    .s_ack_i  (s_ack_i),
    .m_dat_o  (m_dat_o),
    .m_ack_o  (m_ack_o)
  );

endmodule

module wb_addr_decoder_chk #(
  parameter int N_SLV  = 4,
  parameter int DATA_W = 32
) (
  input logic              m_stb_i,
  input logic              m_cyc_i,
  input logic              m_ack_o,
  input logic [DATA_W-1:0] m_dat_o,
  input logic [N_SLV-1:0]  s_stb_o,
  input logic [N_SLV-1:0]  s_cyc_o,
  input logic [N_SLV-1:0]  s_ack_i
);
  always_comb begin
    a_r3_single_strobe: assert ($onehot0(s_stb_o))
      else $error("R3: more than one slave strobe high");
    for (int i = 0; i < N_SLV; i++) begin
      a_r2_stb_gated: assert (!s_stb_o[i] || (m_stb_i && m_cyc_i))
        else $error("R2: slave strobe without master request");
      a_r2_cyc_gated: assert (!s_cyc_o[i] || (m_stb_i && m_cyc_i))
        else $error("R2: slave cycle without master request");
    end
    a_r4_ack_source: assert (!m_ack_o || ((s_ack_i & s_stb_o) != '0))
      else $error("R4: master ack without a strobed acking slave");
    a_r5_miss_zero: assert (!(m_stb_i && m_cyc_i && s_stb_o == '0) || (m_dat_o == '0 && !m_ack_o))
      else $error("R5: unmatched request returned data or ack");
  end
endmodule

bind wb_addr_decoder wb_addr_decoder_chk #(
  .N_SLV  (N_SLV),
  .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/wb_addr_decoder_bench.sv
module wb_addr_decoder_bench;
  import wbdec_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Shared master-side stimulus
  logic [23:0] io_adr  = '0;
  logic [31:0] mem_adr = '0;
  logic [31:0] wdat    = '0;
  logic [3:0]  wsel    = '0;
  logic        wwe     = 1'b0;
  logic        stb     = 1'b0;
  logic        cyc     = 1'b0;
  logic [3:0]  ackv    = '0;

  localparam logic [MAX_SLV-1:0][31:0] C_BASE =
    {{13{32'h0}}, 32'hFF80_0000, 32'hFF40_0000, 32'hFF00_0000};

  // Instance A: I/O mode defaults
  logic [31:0] a_mdat; logic a_mack; logic [95:0] a_sadr; logic [31:0] a_sdo;
  logic [3:0] a_ssel, a_stb, a_cyc; logic a_swe;
  wire  [127:0] a_sdi = {32'h1000_0003, 32'h1000_0002, 32'h1000_0001, 32'h1000_0000};
  wb_addr_decoder #(.MODE(WBD_IO)) u_wb_addr_decoder (
    .m_adr_i(io_adr), .m_dat_i(wdat), .m_sel_i(wsel), .m_we_i(wwe),
    .m_stb_i(stb), .m_cyc_i(cyc), .m_dat_o(a_mdat), .m_ack_o(a_mack),
    .s_adr_o(a_sadr), .s_dat_o(a_sdo), .s_sel_o(a_ssel), .s_we_o(a_swe),
    .s_stb_o(a_stb), .s_cyc_o(a_cyc), .s_dat_i(a_sdi), .s_ack_i(ackv));

  // Instance B: memory mode defaults
  logic [31:0] b_mdat; logic b_mack; logic [127:0] b_sadr; logic [31:0] b_sdo;
  logic [3:0] b_ssel, b_stb, b_cyc; logic b_swe;
  wire  [127:0] b_sdi = {32'h2000_0003, 32'h2000_0002, 32'h2000_0001, 32'h2000_0000};
  wb_addr_decoder #(.MODE(WBD_MEM)) u_mem (
    .m_adr_i(mem_adr), .m_dat_i(wdat), .m_sel_i(wsel), .m_we_i(wwe),
    .m_stb_i(stb), .m_cyc_i(cyc), .m_dat_o(b_mdat), .m_ack_o(b_mack),
    .s_adr_o(b_sadr), .s_dat_o(b_sdo), .s_sel_o(b_ssel), .s_we_o(b_swe),
    .s_stb_o(b_stb), .s_cyc_o(b_cyc), .s_dat_i(b_sdi), .s_ack_i(ackv));

  // Instance C: two-bit decode, three ports
  logic [31:0] c_mdat; logic c_mack; logic [71:0] c_sadr; logic [31:0] c_sdo;
  logic [3:0] c_ssel; logic [2:0] c_stb, c_cyc; logic c_swe;
  wire  [95:0] c_sdi = {32'h3000_0002, 32'h3000_0001, 32'h3000_0000};
  wb_addr_decoder #(.MODE(WBD_IO), .N_SLV(3), .DEC_W(2), .BASE(C_BASE)) u_narrow (
    .m_adr_i(io_adr), .m_dat_i(wdat), .m_sel_i(wsel), .m_we_i(wwe),
    .m_stb_i(stb), .m_cyc_i(cyc), .m_dat_o(c_mdat), .m_ack_o(c_mack),
    .s_adr_o(c_sadr), .s_dat_o(c_sdo), .s_sel_o(c_ssel), .s_we_o(c_swe),
    .s_stb_o(c_stb), .s_cyc_o(c_cyc), .s_dat_i(c_sdi), .s_ack_i(ackv[2:0]));

  typedef struct {
    string       req;
    logic [3:0]  ea, eb, ec;
    logic        ka, kb, kc;
    logic [31:0] da, db, dc;
    logic [23:0] la, lc;
    logic [31:0] lb;
    logic [31:0] dat;
    logic [3:0]  sel;
    logic        we;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirement text only.
  function automatic logic [3:0] ref_hit_a(input logic [23:0] a);   // R8
    return (a[23:16] < 8'd4) ? (4'b0001 << a[23:16]) : 4'b0000;
  endfunction
  function automatic logic [3:0] ref_hit_b(input logic [31:0] a);   // R9
    return (a[31:24] >= 8'd1 && a[31:24] <= 8'd4) ? (4'b0001 << (a[31:24] - 8'd1)) : 4'b0000;
  endfunction
  function automatic logic [3:0] ref_hit_c(input logic [23:0] a);   // R10
    return (a[23:22] != 2'b11) ? (4'b0001 << a[23:22]) : 4'b0000;
  endfunction
  function automatic logic [31:0] ref_dat(input logic [3:0] h, input logic [31:0] tag);
    for (int k = 0; k < 4; k++) if (h[k]) return tag | 32'(k);
    return 32'h0;  // R5
  endfunction

  task automatic apply(input string req, input logic [23:0] ia, input logic [31:0] ma,
                       input logic s, input logic c, input logic [3:0] ak);
    item_t it;
    logic [3:0] ha, hb, hc;
    @(posedge clk);
    #1;
    io_adr = ia; mem_adr = ma; stb = s; cyc = c; ackv = ak;
    wdat = {ia[15:0], ma[15:0]} ^ 32'h5A5A_A5A5;
    wsel = ia[3:0]; wwe = ma[0];
    ha = ref_hit_a(ia); hb = ref_hit_b(ma); hc = ref_hit_c(ia);
    it.req = req;
    it.ea = (s && c) ? ha : 4'b0;
    it.eb = (s && c) ? hb : 4'b0;
    it.ec = (s && c) ? hc : 4'b0;
    it.ka = |(it.ea & ak);
    it.kb = |(it.eb & ak);
    it.kc = |(it.ec & {1'b0, ak[2:0]});
    it.da = ref_dat(ha, 32'h1000_0000);
    it.db = ref_dat(hb, 32'h2000_0000);
    it.dc = ref_dat(hc, 32'h3000_0000);
    it.la = {8'h00, ia[15:0]};   // R7: size 16
    it.lb = {8'h00, ma[23:0]};   // R7: size 24
    it.lc = {2'b00, ia[21:0]};   // R7: size 22
    it.dat = wdat; it.sel = wsel; it.we = wwe;
    sb_q.push_back(it);
  endtask

  // Monitor: results are combinational (R11), due in the cycle of the stimulus.
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(a_stb == it.ea, it.req, "A strobe", 32'(a_stb), 32'(it.ea));
      chk(b_stb == it.eb, it.req, "B strobe", 32'(b_stb), 32'(it.eb));
      chk(c_stb == it.ec[2:0], it.req, "C strobe", 32'(c_stb), 32'(it.ec));
      chk(a_cyc == it.ea && b_cyc == it.eb && c_cyc == it.ec[2:0], "R2", "cycle mirrors strobe",
          {20'h0, a_cyc, b_cyc, 1'b0, c_cyc}, {20'h0, it.ea, it.eb, it.ec});
      chk($countones(a_stb) <= 1 && $countones(b_stb) <= 1 && $countones(c_stb) <= 1,
          "R3", "single strobe", {20'h0, a_stb, b_stb, 1'b0, c_stb}, 32'h0);
      chk(a_mack == it.ka, "R4 R11", "A ack", 32'(a_mack), 32'(it.ka));
      chk(b_mack == it.kb, "R4 R11", "B ack", 32'(b_mack), 32'(it.kb));
      chk(c_mack == it.kc, "R4 R11", "C ack", 32'(c_mack), 32'(it.kc));
      chk(a_mdat == it.da, (it.da == 0) ? "R5" : "R4", "A read data", a_mdat, it.da);
      chk(b_mdat == it.db, (it.db == 0) ? "R5" : "R4", "B read data", b_mdat, it.db);
      chk(c_mdat == it.dc, (it.dc == 0) ? "R5" : "R4", "C read data", c_mdat, it.dc);
      for (int k = 0; k < 4; k++) begin
        chk(a_sadr[k*24 +: 24] == it.la, "R7", "A lane", 32'(a_sadr[k*24 +: 24]), 32'(it.la));
        chk(b_sadr[k*32 +: 32] == it.lb, "R7", "B lane", b_sadr[k*32 +: 32], it.lb);
      end
      for (int k = 0; k < 3; k++)
        chk(c_sadr[k*24 +: 24] == it.lc, "R7", "C lane", 32'(c_sadr[k*24 +: 24]), 32'(it.lc));
      chk(a_sdo == it.dat && b_sdo == it.dat && c_sdo == it.dat, "R6", "write data",
          a_sdo, it.dat);
      chk(a_ssel == it.sel && b_ssel == it.sel && c_ssel == it.sel && a_swe == it.we
          && b_swe == it.we && c_swe == it.we, "R6", "sel/we",
          {27'h0, a_swe, a_ssel}, {27'h0, it.we, it.sel});
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    // Idle bus at start: no strobes, no ack, lanes zero.
    repeat (3) apply("R2 reset", 24'h0, 32'h0, 1'b0, 1'b0, 4'h0);
    // R8 / R9: each default port hit in both modes, all slaves acking.
    for (int k = 0; k < 4; k++)
      apply("R8 R9", {8'(k), 16'hC3A5}, {8'(k + 1), 24'h00_1234}, 1'b1, 1'b1, 4'hF);
    // R10: two-bit field sweep; memory addresses below 0x01000000 miss (R5).
    for (int k = 0; k < 4; k++)
      apply("R10", {2'(k), 22'h00_0001}, {8'h00, 2'(k), 22'h1}, 1'b1, 1'b1, 4'hF);
    // R5: unmapped on every instance.
    apply("R5", 24'hFF_0000, 32'hFF00_0000, 1'b1, 1'b1, 4'hF);
    apply("R5", 24'hC4_8000, 32'h0500_0000, 1'b1, 1'b1, 4'hF);
    // R2: strobe or cycle missing.
    apply("R2", 24'h01_0000, 32'h0200_0000, 1'b0, 1'b1, 4'hF);
    apply("R2", 24'h01_0000, 32'h0200_0000, 1'b1, 1'b0, 4'hF);
    // R4: the selected slave is stalling while the others assert ack.
    apply("R4", 24'h01_0000, 32'h0200_0000, 1'b1, 1'b1, 4'b1101);
    apply("R4", 24'h01_0000, 32'h0200_0000, 1'b1, 1'b1, 4'b0010);
    // R1: low bits at both extremes leave the selection unchanged.
    apply("R1", 24'h02_0000, 32'h0300_0000, 1'b1, 1'b1, 4'hF);
    apply("R1", 24'h02_FFFF, 32'h03FF_FFFF, 1'b1, 1'b1, 4'hF);
    apply("R1", 24'h3F_FFFF, 32'h04AB_CDEF, 1'b1, 1'b1, 4'hF);
    apply("R2 idle", 24'h0, 32'h0, 1'b0, 1'b0, 4'h0);
    repeat (3) @(posedge clk);
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule